// File: doc/BRIEF.md
# Gamma-Corrected Raster Scan-Out

This block turns a stream of packed pixel words into a raster video signal. A pixel clock drives a pair of position counters that produce active-low horizontal and vertical sync pulses. With the default parameters and a 25 MHz clock, the raster is 640x480 with 800 clocks per line and 525 lines per frame, which gives a 60 Hz refresh.

The block pulls one 32-bit word for each visible pixel from an upstream FIFO and splits it into red, green and blue bytes. Each byte is passed through its own 256-entry gamma table. The result is driven out on the RGB pins, aligned with the syncs and a display-enable flag. The three tables are loaded through a simple write port.

The pixel input is a valid/ready stream. Ready is high only while the raster is inside the visible area. A word moves when valid and ready are both high on a clock edge. The source may not stall the raster: if ready is high and valid is low, that pixel is shown black and a sticky underflow flag is raised. Outside the visible area, valid is ignored and nothing is consumed.

Top module: `vga_gamma_scanout`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hsync_n` and `vsync_n` are 1, `de` is 0, all colour outputs are 0 and `underflow` is 0.
- R2: The horizontal counter runs through H_ACTIVE+H_FP+H_SYNC+H_BP clocks per line. The horizontal sync is low for H_SYNC clocks, starting at column H_ACTIVE+H_FP.
- R3: The vertical counter advances once per line and runs through V_ACTIVE+V_FP+V_SYNC+V_BP lines. The vertical sync is low for the V_SYNC lines starting at line V_ACTIVE+V_FP.
- R4: `pix_ready` is high exactly when the column is below H_ACTIVE and the line is below V_ACTIVE. Valid is ignored in every other cycle, and no word is consumed there.
- R5: Each accepted word is split as red = bits 31:24, green = bits 23:16 and blue = bits 15:8. Bits 7:0 have no effect on the output.
- R6: Each colour output equals that channel's gamma table entry, indexed by the byte that was unpacked for it.
- R7: A write with `lut_we` high stores `lut_wdata` at `lut_addr` in the table chosen by `lut_chan`: 0 selects red, 1 green and 2 blue. A write with `lut_chan` = 3 changes no table.
- R8: The colour outputs, `de`, `hsync_n` and `vsync_n` all appear two clocks after the raster position they belong to, and stay aligned with each other.
- R9: The colour outputs are 0 whenever `de` is 0.
- R10: A visible-area cycle with `pix_valid` low outputs black for that pixel and sets `underflow` on the next clock. `underflow` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Upstream word available |
| pix_ready | output | 1 | Word taken this cycle (visible area only) |
| pix_data | input | 32 | Packed word: R, G, B, unused byte |
| lut_we | input | 1 | Gamma table write strobe |
| lut_chan | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| lut_addr | input | 8 | Table entry index |
| lut_wdata | input | 8 | Table entry value |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable (visible pixel) |
| red | output | 8 | Corrected red |
| green | output | 8 | Corrected green |
| blue | output | 8 | Corrected blue |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The bench shrinks the raster to a 15x8 frame and checks every cycle of three whole frames against a position computed from the clock count.

- **Sync edges and counter wrap.** An off-by-one in either counter shifts a sync pulse or stretches a line, and the per-cycle comparison of `hsync_n`, `vsync_n` and `de` exposes it.
- **Reading during blanking.** A design that asserts ready during blanking, or that ignores valid, consumes words at the wrong time. The word sequence then falls out of step, and every later pixel value is wrong.
- **Pipeline alignment.** A design that skews its sync stage against its colour stage by one clock fails on every line.
- **Table addressing and lanes.** Each table holds a different curve, so a swapped lane, a swapped table or a stored dummy byte gives wrong colours.
- **Ignored write and sticky flag.** The bench issues a table write with selector 3 and expects no table to change. It opens deliberate gaps in one frame and expects black pixels there, with the flag raised exactly one clock later and held until the next reset.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  // Gamma table selector codes
  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_NONE  = 2'd3
  } chan_e;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/vga_timing_gen.sv
module vga_timing_gen #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          active,
  output logic          hs_n,
  output logic          vs_n
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  always_comb begin
    active = (h_cnt < H_VIS) && (v_cnt < V_VIS);
    hs_n   = !((h_cnt >= HS_BEG) && (h_cnt < HS_END));
    vs_n   = !((v_cnt >= VS_BEG) && (v_cnt < VS_END));
  end
endmodule

// File: rtl/vga_gamma_lut.sv
module vga_gamma_lut #(
  parameter int CW = 8,
  localparam int DEPTH = 1 << CW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vga_gamma_scanout.sv
module vga_gamma_scanout #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int CW       = 8,
  localparam int PW      = 4 * CW,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [PW-1:0] pix_data,
  input  logic          lut_we,
  input  logic [1:0]    lut_chan,
  input  logic [CW-1:0] lut_addr,
  input  logic [CW-1:0] lut_wdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic [CW-1:0] red,
  output logic [CW-1:0] green,
  output logic [CW-1:0] blue,
  output logic          underflow
);
  import vga_scan_pkg::*;

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          active, hs_n, vs_n;

  vga_timing_gen #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .active(active), .hs_n(hs_n), .vs_n(vs_n)
  );

  // The upstream FIFO is read only while the raster is visible
  assign pix_ready = active;

  // Stage 1: latch colour bytes and raster flags
  logic [CW-1:0] s1_idx  [NUM_CH];
  logic [CW-1:0] lut_out [NUM_CH];
  logic          s1_de, s1_ok, s1_hs, s1_vs;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) s1_idx[c] <= '0;
      else        s1_idx[c] <= pix_data[PW-1-c*CW -: CW];
    end

    vga_gamma_lut #(.CW(CW)) u_lut (
      .clk  (clk),
      .we   (lut_we && (lut_chan == 2'(c))),
      .waddr(lut_addr),
      .wdata(lut_wdata),
      .raddr(s1_idx[c]),
      .rdata(lut_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_de <= 1'b0;
      s1_ok <= 1'b0;
      s1_hs <= 1'b1;
      s1_vs <= 1'b1;
    end else begin
      s1_de <= active;
      s1_ok <= active && pix_valid;
      s1_hs <= hs_n;
      s1_vs <= vs_n;
    end
  end

  // Stage 2: gamma-corrected output, blanked or starved pixels black
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de      <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      red     <= '0;
      green   <= '0;
      blue    <= '0;
    end else begin
      de      <= s1_de;
      hsync_n <= s1_hs;
      vsync_n <= s1_vs;
      red     <= s1_ok ? lut_out[CH_RED]   : '0;
      green   <= s1_ok ? lut_out[CH_GREEN] : '0;
      blue    <= s1_ok ? lut_out[CH_BLUE]  : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       underflow <= 1'b0;
    else if (pix_ready && !pix_valid) underflow <= 1'b1;
  end
endmodule

// File: rtl/vga_scan_checker.sv
module vga_scan_checker #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int CW       = 8,
  localparam int PW      = 4 * CW,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [PW-1:0] pix_data,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          de,
  input logic [CW-1:0] red,
  input logic [CW-1:0] green,
  input logic [CW-1:0] blue,
  input logic          underflow
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SYNC);

  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == H_LAST) |=> (h_cnt == '0));

  p_hsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt >= HS_BEG && h_cnt < HS_END) |=> ##1 !hsync_n);

  p_vsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt >= VS_BEG && v_cnt < VS_END) |=> ##1 !vsync_n);

  p_ready_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt >= H_VIS || v_cnt >= V_VIS) |-> !pix_ready);

  p_data_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && pix_valid) |-> !$isunknown(pix_data));

  p_de_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> ##1 de);

  p_rgb_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (red == '0 && green == '0 && blue == '0));

  p_underflow_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> underflow);

  p_underflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

bind vga_gamma_scanout vga_scan_checker #(
  .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
  .red(red), .green(green), .blue(blue), .underflow(underflow)
);

// File: tb/vga_gamma_scanout_tb.sv
module vga_gamma_scanout_tb;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [31:0] pix_data = '0;
  logic        lut_we = 1'b0;
  logic [1:0]  lut_chan = '0;
  logic [7:0]  lut_addr = '0, lut_wdata = '0;
  logic        hsync_n, vsync_n, de, underflow;
  logic [7:0]  red, green, blue;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vga_gamma_scanout #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .CW(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .lut_we(lut_we), .lut_chan(lut_chan),
    .lut_addr(lut_addr), .lut_wdata(lut_wdata), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de), .red(red), .green(green), .blue(blue),
    .underflow(underflow)
  );

  function automatic logic [7:0] curve(int ch, logic [7:0] v);
    case (ch)
      0:       return ~v;
      1:       return 8'((int'(v) * int'(v)) >> 8);
      default: return v ^ 8'h5A;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Expected output ring, indexed by cycle modulo 4
  logic [7:0] e_r [4], e_g [4], e_b [4];
  logic       e_de [4], e_hs [4], e_vs [4];

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k = 0;
    bit err_m = 0;
    for (int i = 0; i < 4; i++) begin
      e_r[i] = 0; e_g[i] = 0; e_b[i] = 0;
      e_de[i] = 0; e_hs[i] = 1; e_vs[i] = 1;
    end
    // Load the tables during reset (R7)
    for (int ch = 0; ch < 3; ch++)
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        lut_we = 1; lut_chan = 2'(ch); lut_addr = 8'(a); lut_wdata = curve(ch, 8'(a));
      end
    // Selector 3 must leave every table untouched (R7)
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      lut_we = 1; lut_chan = 2'd3; lut_addr = 8'(a); lut_wdata = 8'h00;
    end
    @(negedge clk);
    lut_we = 0;
    // R1: reset state
    check("R1 hsync_n", hsync_n, 1); check("R1 vsync_n", vsync_n, 1);
    check("R1 de", de, 0); check("R1 rgb", {red, green, blue}, 0);
    check("R1 underflow", underflow, 0);
    rst_n = 1;
    for (int t = 0; t < 3 * FT; t++) begin
      int p, h, v, f, s;
      bit act, hs, vs;
      logic [7:0] lr, lg, lb;
      if (t > 0) @(negedge clk);
      s = t % 4;
      // R8 R2 R3: aligned outputs two clocks after their position
      check("R8 de", de, e_de[s]);
      check("R2 hsync_n", hsync_n, e_hs[s]);
      check("R3 vsync_n", vsync_n, e_vs[s]);
      check(e_de[s] ? "R5 R6 R7 red" : "R9 red", red, e_r[s]);
      check(e_de[s] ? "R5 R6 R7 green" : "R9 green", green, e_g[s]);
      check(e_de[s] ? "R5 R6 R7 blue" : "R9 blue", blue, e_b[s]);
      check("R10 underflow", underflow, err_m);
      p = t % FT; h = p % HT; v = p / HT; f = t / FT;
      act = (h < HA) && (v < VA);
      hs  = !(h >= HA + HF && h < HA + HF + HS);
      vs  = !(v >= VA + VF && v < VA + VF + VS);
      // Gaps only in frame 1; valid held high in blanking otherwise (R4)
      pix_valid = !(f == 1 && act && (h % 5 == 3));
      lr = 8'(k * 7 + 3); lg = 8'(k * 13 + 1); lb = 8'(k * 29 + 5);
      pix_data = {lr, lg, lb, 8'(k) ^ 8'hC3};
      #1;
      check("R4 pix_ready", pix_ready, act);
      s = (t + 2) % 4;
      e_de[s] = act; e_hs[s] = hs; e_vs[s] = vs;
      if (act && pix_valid) begin
        e_r[s] = curve(0, lr); e_g[s] = curve(1, lg); e_b[s] = curve(2, lb);
        k++;
      end else begin
        e_r[s] = 0; e_g[s] = 0; e_b[s] = 0;
      end
      if (act && !pix_valid) err_m = 1;
    end
    // R10: flag clears only through reset
    @(negedge clk);
    check("R10 underflow held", underflow, 1);
    rst_n = 0;
    @(negedge clk);
    check("R1 underflow after reset", underflow, 0);
    check("R1 de after reset", de, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule